// File: doc/BRIEF.md
# I2C Command Queue Executor

This block turns a stream of 11-bit command words into byte-level I2C transactions. Each word has a 3-bit operation code and an 8-bit argument. Depending on the code, the argument is an address byte, a payload byte or a receive count. Commands enter a small queue through a valid/ready handshake. A single executor takes them one at a time. It drives a byte-level bus agent that selects an address and reports ACK or NACK, writes a byte, reads a byte or sends a stop.

Payload bytes are held in a transmit buffer. They go onto the bus as soon as a command of any other kind arrives, or when the buffer is full. Received bytes pass through an optional pattern matcher before they reach a receive queue. In match-only mode the matcher drops the bytes that come before a match. The executor produces one-cycle event pulses for NACK, stop, end of packet and data match. It can also close a transaction by itself, either before a new start or when software drains the last received byte.

Top module: `i2c_cmdq_exec`

## Requirements
- R1: After reset `busy`, `bus_req` and `rx_valid` are low and `cmd_ready` is high.
- R2: A command word carries the operation in bits 10:8 and the argument in bits 7:0. The codes are: 0 transmit, 1 receive, 2 stop, 3 receive-and-discard, 4 start, 5 start expecting NACK, 6 high-speed start, 7 high-speed start expecting NACK. A normal start (4 or 6) issues an address operation with the argument byte. If the address is acknowledged, the target is selected. If it is not acknowledged, `evt_nack` pulses and no target is selected.
- R3: Transmit bytes for a selected target are buffered. Before any non-transmit command runs, the buffered bytes are written to the bus in arrival order.
- R4: While `cfg_enable` is low, buffered transmit bytes are discarded without any bus write.
- R5: A receive command with argument N performs N+1 read operations and queues the bytes in order. Code 3 performs the reads but queues nothing.
- R6: Transmit and receive commands issued while no target is selected cause no bus operation and queue nothing.
- R7: A stop sends a bus stop operation only if a target is selected. It always releases the target and pulses `evt_stop` and `evt_eop` in the same cycle.
- R8: A start issued while a target is selected is a repeated start. It pulses `evt_eop` without `evt_stop` and without a bus stop.
- R9: A start expecting NACK (5 or 7) pulses `evt_nack` when the address is acknowledged, pulses nothing when it is not, and leaves no target selected.
- R10: When `cfg_autostop` is high, a normal start is preceded by a stop sequence. Popping the last byte of the receive queue also triggers a stop.
- R11: If the last-byte pop and a newly queued command fall in the same cycle, the triggered stop runs before that command.
- R12: Matcher modes on `cfg_match_mode` are: 2 argument-0 or argument-1 at the first byte; 3 the same at any byte; 4 argument-0 followed by argument-1 on the first two bytes; 5 that pair anywhere; 6 byte masked by argument-1 equals argument-0 masked by argument-1, first byte only; 7 that masked test on any byte. Codes 0 and 1 disable matching. The first match of a receive command pulses `evt_match`.
- R13: With `cfg_match_only` high and matching enabled, bytes received before the match are dropped. For a pair match, the first byte of the pair is kept.
- R14: `bus_req` and its operation stay stable until `bus_done`, and they drop in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Controller enable; when low, buffered transmit bytes are discarded |
| cfg_autostop | input | 1 | Automatic stop before a start and after the receive queue drains |
| cfg_match_mode | input | 3 | Matcher mode |
| cfg_match_only | input | 1 | Keep only bytes from the match onward |
| cfg_match0 | input | 8 | Matcher argument 0 |
| cfg_match1 | input | 8 | Matcher argument 1 (second byte or mask) |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command queue has room |
| cmd_word | input | 11 | Command code and argument |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | 0 address, 1 write, 2 read, 3 stop |
| bus_wdata | output | 8 | Address byte or write byte |
| bus_done | input | 1 | Bus operation complete |
| bus_ack | input | 1 | Address acknowledged (valid with done) |
| bus_rdata | input | 8 | Read byte (valid with done) |
| rx_valid | output | 1 | Receive queue not empty |
| rx_ready | input | 1 | Pop receive byte |
| rx_data | output | 8 | Head of receive queue |
| busy | output | 1 | Executor is processing a command |
| evt_nack | output | 1 | NACK event pulse |
| evt_stop | output | 1 | Stop event pulse |
| evt_eop | output | 1 | End-of-packet event pulse |
| evt_match | output | 1 | Data match event pulse |

## Verification
Two things can land on the same clock edge. One is a software pop that drains the receive queue with automatic stop set. The other is the arrival of a new start command. The bench drives both on one edge while a target is selected and then looks at the order of the bus operations that follow. A single stop followed by the new address operation shows that the drain stop was served first. A stop, an address and then a second stop would show the command had jumped ahead.

// File: rtl/i2c_cq_pkg.sv
package i2c_cq_pkg;
    localparam int BYTE_W = 8;
    localparam int CODE_W = 3;

    typedef enum logic [2:0] {
        CMD_TX          = 3'd0,
        CMD_RX          = 3'd1,
        CMD_STOP        = 3'd2,
        CMD_RX_DROP     = 3'd3,
        CMD_START       = 3'd4,
        CMD_START_NK    = 3'd5,
        CMD_HS_START    = 3'd6,
        CMD_HS_START_NK = 3'd7
    } cmd_code_e;

    typedef enum logic [1:0] {
        BOP_ADDR  = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_READ  = 2'd2,
        BOP_STOP  = 2'd3
    } bus_op_e;

    typedef enum logic [2:0] {
        MM_OFF        = 3'd0,
        MM_OFF_ALT    = 3'd1,
        MM_FIRST_ONE  = 3'd2,
        MM_ANY_ONE    = 3'd3,
        MM_FIRST_PAIR = 3'd4,
        MM_ANY_PAIR   = 3'd5,
        MM_FIRST_MASK = 3'd6,
        MM_ANY_MASK   = 3'd7
    } match_mode_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DECODE, ST_FLUSH, ST_WR_WAIT, ST_STOP, ST_STOP_WAIT,
        ST_ADDR, ST_ADDR_WAIT, ST_RD, ST_RD_WAIT, ST_PUSH_CUR
    } exec_state_e;

    typedef struct packed {
        exec_state_e        st;
        cmd_code_e          code;
        logic [BYTE_W-1:0]  arg;
        logic               sel;
        logic [BYTE_W-1:0]  cnt;
        logic               ret_addr;
        logic               stop_pend;
        logic               req;
        bus_op_e            op;
        logic [BYTE_W-1:0]  wdata;
        logic [BYTE_W-1:0]  hold;
        logic               ev_nack;
        logic               ev_stop;
        logic               ev_eop;
        logic               ev_match;
    } exec_regs_t;
endpackage

// File: rtl/i2c_cq_fifo.sv
module i2c_cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wr_d, wr_q, rd_d, rd_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          do_push, do_pop;

    always_comb begin
        do_push = push && (cnt_q != CW'(DEPTH));
        do_pop  = pop && (cnt_q != '0);
        wr_d    = wr_q;
        rd_d    = rd_q;
        cnt_d   = cnt_q;
        if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : AW'(wr_q + 1'b1);
        if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : AW'(rd_q + 1'b1);
        if (do_push && !do_pop) cnt_d = CW'(cnt_q + 1'b1);
        if (do_pop && !do_push) cnt_d = CW'(cnt_q - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_d;
            rd_q  <= rd_d;
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= wdata;
    end

    assign rdata = mem_q[rd_q];
    assign count = cnt_q;
endmodule

// File: rtl/i2c_cq_match.sv
module i2c_cq_match
    import i2c_cq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [BYTE_W-1:0] din,
    input  logic [2:0]        mode,
    input  logic [BYTE_W-1:0] arg0,
    input  logic [BYTE_W-1:0] arg1,
    input  logic              only,
    output logic              hit,
    output logic              emit_prev,
    output logic              emit_cur,
    output logic [BYTE_W-1:0] prev_byte
);
    typedef struct packed {
        logic [1:0]        idx;
        logic [BYTE_W-1:0] prev;
        logic              found;
    } mstate_t;

    mstate_t     d, q;
    match_mode_e m;
    logic        single, pair, masked, cand, active, is_pair, found_now;

    always_comb begin
        m       = match_mode_e'(mode);
        single  = (din == arg0) || (din == arg1);
        pair    = (q.idx != 2'd0) && (q.prev == arg0) && (din == arg1);
        masked  = (din & arg1) == (arg0 & arg1);
        active  = !(m inside {MM_OFF, MM_OFF_ALT});
        is_pair = m inside {MM_FIRST_PAIR, MM_ANY_PAIR};
        unique case (m)
            MM_FIRST_ONE:  cand = single && (q.idx == 2'd0);
            MM_ANY_ONE:    cand = single;
            MM_FIRST_PAIR: cand = pair && (q.idx == 2'd1);
            MM_ANY_PAIR:   cand = pair;
            MM_FIRST_MASK: cand = masked && (q.idx == 2'd0);
            MM_ANY_MASK:   cand = masked;
            default:       cand = 1'b0;
        endcase
        hit       = adv && active && cand && !q.found;
        found_now = q.found || hit;
        emit_cur  = !active || !only || found_now;
        emit_prev = active && only && hit && is_pair;
        prev_byte = q.prev;

        d = q;
        if (clr) begin
            d = '0;
        end else if (adv) begin
            d.idx   = (q.idx == 2'd3) ? 2'd3 : q.idx + 2'd1;
            d.prev  = din;
            d.found = found_now;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/i2c_cmdq_exec.sv
module i2c_cmdq_exec
    import i2c_cq_pkg::*;
#(
    parameter int CMD_DEPTH = 4,
    parameter int TX_DEPTH  = 4,
    parameter int RX_DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_autostop,
    input  logic [2:0]        cfg_match_mode,
    input  logic              cfg_match_only,
    input  logic [7:0]        cfg_match0,
    input  logic [7:0]        cfg_match1,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [10:0]       cmd_word,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [7:0]        bus_wdata,
    input  logic              bus_done,
    input  logic              bus_ack,
    input  logic [7:0]        bus_rdata,
    output logic              rx_valid,
    input  logic              rx_ready,
    output logic [7:0]        rx_data,
    output logic              busy,
    output logic              evt_nack,
    output logic              evt_stop,
    output logic              evt_eop,
    output logic              evt_match
);
    localparam int WORD_W = CODE_W + BYTE_W;
    localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
    localparam int TX_CW  = $clog2(TX_DEPTH + 1);
    localparam int RX_CW  = $clog2(RX_DEPTH + 1);

    exec_regs_t q, n;

    logic [WORD_W-1:0] cmd_head;
    logic [CMD_CW-1:0] cmd_cnt;
    logic [BYTE_W-1:0] tx_head, rx_wdata;
    logic [TX_CW-1:0]  tx_cnt;
    logic [RX_CW-1:0]  rx_cnt;
    logic cmd_push, cmd_pop, tx_push, tx_pop, rx_push, rx_pop;
    logic tx_full, tx_empty, rx_room2, drain_now, took_stop;
    logic m_clr, m_adv, m_hit, m_emit_prev, m_emit_cur;
    logic [BYTE_W-1:0] m_prev;

    assign cmd_ready = (cmd_cnt != CMD_CW'(CMD_DEPTH));
    assign cmd_push  = cmd_valid && cmd_ready;
    assign tx_full   = (tx_cnt == TX_CW'(TX_DEPTH));
    assign tx_empty  = (tx_cnt == '0);
    assign rx_valid  = (rx_cnt != '0);
    assign rx_pop    = rx_valid && rx_ready;
    assign rx_room2  = (rx_cnt <= RX_CW'(RX_DEPTH - 2));
    assign drain_now = rx_pop && cfg_autostop && (rx_cnt == RX_CW'(1));

    i2c_cq_fifo #(.W(WORD_W), .DEPTH(CMD_DEPTH)) cmd_q_i (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(cmd_word),
        .pop(cmd_pop), .rdata(cmd_head), .count(cmd_cnt));

    i2c_cq_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(q.arg),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt));

    i2c_cq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_wdata),
        .pop(rx_pop), .rdata(rx_data), .count(rx_cnt));

    i2c_cq_match match_i (
        .clk(clk), .rst_n(rst_n), .clr(m_clr), .adv(m_adv), .din(bus_rdata),
        .mode(cfg_match_mode), .arg0(cfg_match0), .arg1(cfg_match1),
        .only(cfg_match_only), .hit(m_hit), .emit_prev(m_emit_prev),
        .emit_cur(m_emit_cur), .prev_byte(m_prev));

    always_comb begin
        n = q;
        n.ev_nack  = 1'b0;
        n.ev_stop  = 1'b0;
        n.ev_eop   = 1'b0;
        n.ev_match = 1'b0;
        cmd_pop   = 1'b0;
        tx_push   = 1'b0;
        tx_pop    = 1'b0;
        rx_push   = 1'b0;
        rx_wdata  = bus_rdata;
        m_clr     = 1'b0;
        m_adv     = 1'b0;
        took_stop = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                if (q.stop_pend || drain_now) begin
                    took_stop   = 1'b1;
                    n.stop_pend = 1'b0;
                    n.code      = CMD_STOP;
                    n.st        = ST_DECODE;
                end else if (cmd_cnt != '0) begin
                    cmd_pop = 1'b1;
                    n.code  = cmd_code_e'(cmd_head[WORD_W-1:BYTE_W]);
                    n.arg   = cmd_head[BYTE_W-1:0];
                    n.st    = ST_DECODE;
                end
            end
            ST_DECODE: begin
                if (q.code == CMD_TX) begin
                    if (!q.sel)          n.st = ST_IDLE;
                    else if (!tx_full) begin
                        tx_push = 1'b1;
                        n.st    = ST_IDLE;
                    end else             n.st = ST_FLUSH;
                end else if (!tx_empty) begin
                    n.st = ST_FLUSH;
                end else begin
                    unique case (q.code)
                        CMD_RX, CMD_RX_DROP: begin
                            m_clr = 1'b1;
                            n.cnt = q.arg;
                            n.st  = q.sel ? ST_RD : ST_IDLE;
                        end
                        CMD_STOP: begin
                            n.ret_addr = 1'b0;
                            n.st       = ST_STOP;
                        end
                        CMD_START, CMD_HS_START: begin
                            n.ev_eop   = q.sel;
                            n.ret_addr = 1'b1;
                            n.st       = cfg_autostop ? ST_STOP : ST_ADDR;
                        end
                        default: begin
                            n.ev_eop = q.sel;
                            n.st     = ST_ADDR;
                        end
                    endcase
                end
            end
            ST_FLUSH: begin
                if (tx_empty) begin
                    n.st = ST_DECODE;
                end else if (cfg_enable) begin
                    n.req   = 1'b1;
                    n.op    = BOP_WRITE;
                    n.wdata = tx_head;
                    n.st    = ST_WR_WAIT;
                end else begin
                    tx_pop = 1'b1;
                end
            end
            ST_WR_WAIT: begin
                if (bus_done) begin
                    n.req  = 1'b0;
                    tx_pop = 1'b1;
                    n.st   = ST_FLUSH;
                end
            end
            ST_STOP: begin
                if (q.sel) begin
                    n.req = 1'b1;
                    n.op  = BOP_STOP;
                    n.st  = ST_STOP_WAIT;
                end else begin
                    n.ev_stop = 1'b1;
                    n.ev_eop  = 1'b1;
                    n.st      = q.ret_addr ? ST_ADDR : ST_IDLE;
                end
            end
            ST_STOP_WAIT: begin
                if (bus_done) begin
                    n.req     = 1'b0;
                    n.sel     = 1'b0;
                    n.ev_stop = 1'b1;
                    n.ev_eop  = 1'b1;
                    n.st      = q.ret_addr ? ST_ADDR : ST_IDLE;
                end
            end
            ST_ADDR: begin
                n.req   = 1'b1;
                n.op    = BOP_ADDR;
                n.wdata = q.arg;
                n.st    = ST_ADDR_WAIT;
            end
            ST_ADDR_WAIT: begin
                if (bus_done) begin
                    n.req = 1'b0;
                    n.st  = ST_IDLE;
                    if (q.code inside {CMD_START_NK, CMD_HS_START_NK}) begin
                        n.sel     = 1'b0;
                        n.ev_nack = bus_ack;
                    end else begin
                        n.sel     = bus_ack;
                        n.ev_nack = !bus_ack;
                    end
                end
            end
            ST_RD: begin
                if (q.code == CMD_RX_DROP || rx_room2) begin
                    n.req = 1'b1;
                    n.op  = BOP_READ;
                    n.st  = ST_RD_WAIT;
                end
            end
            ST_RD_WAIT: begin
                if (bus_done) begin
                    n.req = 1'b0;
                    n.st  = (q.cnt == '0) ? ST_IDLE : ST_RD;
                    n.cnt = q.cnt - 1'b1;
                    if (q.code == CMD_RX) begin
                        m_adv      = 1'b1;
                        n.ev_match = m_hit;
                        if (m_emit_prev) begin
                            rx_push  = 1'b1;
                            rx_wdata = m_prev;
                            n.hold   = bus_rdata;
                            n.cnt    = q.cnt;
                            n.st     = ST_PUSH_CUR;
                        end else begin
                            rx_push = m_emit_cur;
                        end
                    end
                end
            end
            ST_PUSH_CUR: begin
                rx_push  = 1'b1;
                rx_wdata = q.hold;
                n.st     = (q.cnt == '0) ? ST_IDLE : ST_RD;
                n.cnt    = q.cnt - 1'b1;
            end
            default: n.st = ST_IDLE;
        endcase

        if (drain_now && !rx_push && !took_stop) n.stop_pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.code <= CMD_TX;
            q.op   <= BOP_ADDR;
        end else begin
            q <= n;
        end
    end

    assign bus_req   = q.req;
    assign bus_op    = q.op;
    assign bus_wdata = q.wdata;
    assign busy      = (q.st != ST_IDLE);
    assign evt_nack  = q.ev_nack;
    assign evt_stop  = q.ev_stop;
    assign evt_eop   = q.ev_eop;
    assign evt_match = q.ev_match;
endmodule

// File: rtl/i2c_cq_checker.sv
module i2c_cq_checker #(
    parameter int RX_DEPTH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         bus_req,
    input logic                         bus_done,
    input logic [1:0]                   bus_op,
    input logic [7:0]                   bus_wdata,
    input logic                         busy,
    input logic                         evt_stop,
    input logic                         evt_eop,
    input logic [$clog2(RX_DEPTH+1)-1:0] rx_cnt
);
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_done |=> bus_req && $stable(bus_op) && $stable(bus_wdata)); // R14
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_done |=> !bus_req); // R14
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R14
    AST_STOP_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        evt_stop |-> evt_eop); // R7
    AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_cnt <= ($clog2(RX_DEPTH+1))'(RX_DEPTH)); // R5
endmodule

bind i2c_cmdq_exec i2c_cq_checker #(.RX_DEPTH(RX_DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_done(bus_done),
    .bus_op(bus_op), .bus_wdata(bus_wdata), .busy(busy),
    .evt_stop(evt_stop), .evt_eop(evt_eop), .rx_cnt(rx_cnt));

// File: tb/i2c_cmdq_exec_tb_top.sv
module i2c_cmdq_exec_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       cfg_enable = 1'b1, cfg_autostop = 1'b0, cfg_match_only = 1'b0;
    logic [2:0] cfg_match_mode = 3'd0;
    logic [7:0] cfg_match0 = 8'h00, cfg_match1 = 8'h00;
    logic       cmd_valid = 1'b0, cmd_ready;
    logic [10:0] cmd_word = '0;
    logic       bus_req, bus_done, bus_ack;
    logic [1:0] bus_op;
    logic [7:0] bus_wdata, bus_rdata;
    logic       rx_valid, rx_ready = 1'b0;
    logic [7:0] rx_data;
    logic       busy, evt_nack, evt_stop, evt_eop, evt_match;

    i2c_cmdq_exec dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_autostop(cfg_autostop),
        .cfg_match_mode(cfg_match_mode), .cfg_match_only(cfg_match_only),
        .cfg_match0(cfg_match0), .cfg_match1(cfg_match1),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .bus_req(bus_req), .bus_op(bus_op), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .busy(busy),
        .evt_nack(evt_nack), .evt_stop(evt_stop), .evt_eop(evt_eop), .evt_match(evt_match));

    // bus agent model: target address 0x50, read data = seed + index
    int         n_ops = 0, rd_k = 0, rd_base = 0;
    logic [7:0] rd_seed = 8'h00;
    logic [1:0] op_log [64];
    logic [7:0] byte_log [64];
    logic [1:0] lat;
    always @(posedge clk) begin
        if (!rst_n) begin
            bus_done <= 1'b0; lat <= 2'd0; bus_ack <= 1'b0; bus_rdata <= 8'h00;
        end else if (bus_done) begin
            bus_done <= 1'b0; lat <= 2'd0;
        end else if (bus_req) begin
            if (lat == 2'd2) begin
                bus_done <= 1'b1;
                bus_ack  <= (bus_wdata[7:1] == 7'h50);
                if (bus_op == 2'd2) begin
                    bus_rdata <= rd_seed + 8'(rd_k - rd_base);
                    rd_k <= rd_k + 1;
                end
                op_log[n_ops % 64]   <= bus_op;
                byte_log[n_ops % 64] <= bus_wdata;
                n_ops <= n_ops + 1;
            end else lat <= lat + 2'd1;
        end
    end

    int c_nack = 0, c_stop = 0, c_eop = 0, c_match = 0;
    always @(posedge clk) begin
        if (evt_nack)  c_nack  <= c_nack + 1;
        if (evt_stop)  c_stop  <= c_stop + 1;
        if (evt_eop)   c_eop   <= c_eop + 1;
        if (evt_match) c_match <= c_match + 1;
    end

    int checks = 0, fails = 0;
    bit done_flag = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(logic [2:0] code, logic [7:0] arg);
        @(negedge clk);
        cmd_word  = {code, arg};
        cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (!busy && !bus_req) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic pop_rx(string req, logic [7:0] exp);
        @(negedge clk);
        chk(req, int'(rx_valid), 1);
        chk(req, int'(rx_data), int'(exp));
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
    endtask

    task automatic set_seed(logic [7:0] s);
        rd_seed = s;
        rd_base = rd_k;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 rx_valid", int'(rx_valid), 0);
        chk("R1 cmd_ready", int'(cmd_ready), 1);
    endtask

    task automatic t_write();
        int b = n_ops, s = c_stop, e = c_eop, k = c_nack;
        send(3'd4, 8'hA0); send(3'd0, 8'h11); send(3'd0, 8'h22); send(3'd2, 8'h00);
        wait_idle();
        chk("R3 op count", n_ops - b, 4);
        chk("R2 addr op", int'(op_log[b]), 0);
        chk("R2 addr byte", int'(byte_log[b]), 'hA0);
        chk("R3 first write", int'(byte_log[b+1]), 'h11);
        chk("R3 second write", int'(byte_log[b+2]), 'h22);
        chk("R14 ordered ops write", int'(op_log[b+2]), 1);
        chk("R7 stop op", int'(op_log[b+3]), 3);
        chk("R7 stop evt", c_stop - s, 1);
        chk("R7 eop evt", c_eop - e, 1);
        chk("R2 no nack on ack", c_nack - k, 0);
    endtask

    task automatic t_nack();
        int b = n_ops, k = c_nack, s = c_stop;
        send(3'd4, 8'hB0); send(3'd0, 8'h33); send(3'd1, 8'h00); send(3'd2, 8'h00);
        wait_idle();
        chk("R2 nack evt", c_nack - k, 1);
        chk("R6 no ops without target", n_ops - b, 1);
        chk("R6 rx empty", int'(rx_valid), 0);
        chk("R7 stop evt without target", c_stop - s, 1);
    endtask

    task automatic t_read();
        int b = n_ops;
        set_seed(8'h20);
        send(3'd4, 8'hA1); send(3'd1, 8'h02);
        wait_idle();
        chk("R5 read count", n_ops - b, 4);
        pop_rx("R5 byte0", 8'h20); pop_rx("R5 byte1", 8'h21); pop_rx("R5 byte2", 8'h22);
        chk("R5 drained", int'(rx_valid), 0);
        b = n_ops;
        send(3'd3, 8'h01);
        wait_idle();
        chk("R5 discard reads", n_ops - b, 2);
        chk("R5 discard stores nothing", int'(rx_valid), 0);
        send(3'd2, 8'h00); wait_idle();
    endtask

    task automatic t_disabled();
        int b = n_ops;
        cfg_enable = 1'b0;
        send(3'd4, 8'hA0); send(3'd0, 8'h44); send(3'd0, 8'h55); send(3'd2, 8'h00);
        wait_idle();
        cfg_enable = 1'b1;
        chk("R4 no writes when disabled", n_ops - b, 2);
        chk("R4 stop follows address", int'(op_log[b+1]), 3);
    endtask

    task automatic t_restart();
        int b = n_ops, s = c_stop, e = c_eop;
        send(3'd4, 8'hA0); send(3'd4, 8'hA1);
        wait_idle();
        chk("R8 eop on restart", c_eop - e, 1);
        chk("R8 no stop on restart", c_stop - s, 0);
        chk("R8 two address ops", n_ops - b, 2);
        send(3'd2, 8'h00); wait_idle();
    endtask

    task automatic t_expect_nack();
        int b = n_ops, k = c_nack;
        send(3'd5, 8'hA0); send(3'd0, 8'h66); send(3'd2, 8'h00);
        wait_idle();
        chk("R9 nack when acked", c_nack - k, 1);
        chk("R9 target not selected", n_ops - b, 1);
        k = c_nack;
        send(3'd7, 8'hB0); wait_idle();
        chk("R9 no nack when unacked", c_nack - k, 0);
    endtask

    task automatic t_match();
        int m = c_match;
        cfg_match_only = 1'b1; cfg_match_mode = 3'd3; cfg_match0 = 8'h42; cfg_match1 = 8'h99;
        set_seed(8'h40);
        send(3'd4, 8'hA1); send(3'd1, 8'h03); wait_idle();
        chk("R12 any-single match evt", c_match - m, 1);
        pop_rx("R13 drop before match", 8'h42); pop_rx("R13 after match", 8'h43);
        chk("R13 nothing else", int'(rx_valid), 0);
        m = c_match;
        cfg_match_mode = 3'd5; cfg_match0 = 8'h61; cfg_match1 = 8'h62;
        set_seed(8'h60);
        send(3'd1, 8'h03); wait_idle();
        chk("R12 pair match evt", c_match - m, 1);
        pop_rx("R13 pair first kept", 8'h61); pop_rx("R13 pair second", 8'h62);
        pop_rx("R13 pair tail", 8'h63);
        m = c_match;
        cfg_match_only = 1'b0; cfg_match_mode = 3'd6; cfg_match0 = 8'h05; cfg_match1 = 8'h0F;
        set_seed(8'h15);
        send(3'd1, 8'h01); wait_idle();
        chk("R12 masked first match evt", c_match - m, 1);
        pop_rx("R12 masked keeps all", 8'h15); pop_rx("R12 masked second", 8'h16);
        m = c_match;
        cfg_match_only = 1'b1; cfg_match_mode = 3'd2; cfg_match0 = 8'h31; cfg_match1 = 8'h31;
        set_seed(8'h30);
        send(3'd1, 8'h01); wait_idle();
        chk("R12 first-only window closed", c_match - m, 0);
        chk("R13 all dropped", int'(rx_valid), 0);
        cfg_match_only = 1'b0; cfg_match_mode = 3'd0;
        send(3'd2, 8'h00); wait_idle();
    endtask

    task automatic t_autostop_race();
        int b, s = c_stop;
        cfg_autostop = 1'b1;
        set_seed(8'h70);
        b = n_ops;
        send(3'd4, 8'hA1); wait_idle();
        chk("R10 stop evt before start", c_stop - s, 1);
        chk("R10 no stop op when unselected", int'(op_log[b]), 0);
        send(3'd1, 8'h00); wait_idle();
        b = n_ops;
        @(negedge clk);
        chk("R11 byte present", int'(rx_data), 'h70);
        rx_ready = 1'b1; cmd_valid = 1'b1; cmd_word = {3'd4, 8'hA0};
        @(negedge clk);
        rx_ready = 1'b0; cmd_valid = 1'b0;
        wait_idle();
        chk("R11 op count", n_ops - b, 2);
        chk("R10 drain stop op", int'(op_log[b]), 3);
        chk("R11 address after stop", int'(op_log[b+1]), 0);
        cfg_autostop = 1'b0;
        send(3'd2, 8'h00); wait_idle();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write();
        t_nack();
        t_read();
        t_disabled();
        t_restart();
        t_expect_nack();
        t_match();
        t_autostop_race();
        finish_run();
    end
endmodule